// File: doc/BRIEF.md
# Cell demultiplexer write router

This block sits on the transmit side of a cell bus. It takes in fixed-length cells and writes each one into one or more of four per-port cell queues. It works out where a cell goes and tells the sender that it may start a cell. It raises that signal only when every queue the cell would reach has room for the whole cell. The destination can be one queue or a set of queues, given by a bitmask. It can come from the address lines or from the first data word of the cell.

The sender raises start-of-cell on the first word of a cell. After that, every clock with enable high carries one more word, until the programmed cell length in bytes is reached. When enable drops in the middle of a cell, the transfer pauses. It resumes from the same position when enable returns. The queue memories are outside this block. For each queue it drives a write strobe, a byte write pointer and a shared data word. For each queue it receives the read pointer of the consumer, and it uses that pointer to check space. Everything runs on one clock.

Top module: `cell_demux_router`

## Requirements
- R1: While reset is high, and in the first cycle after it, every write strobe is low and every queue write pointer is zero. While reset is high, cell-available is low.
- R2: Cell-available is registered. It is high exactly when every queue in the probe set has at least cell-length bytes of free space. In out-band mode the probe set is the decode of the current address lines. In in-band mode it is all four queues. Free space is 128 minus (reserved pointer minus read pointer), taken modulo 256. Starting a cell reserves cell-length bytes in each queue it targets.
- R3: A queue is never written while it already holds 128 bytes, provided the sender obeys cell-available.
- R4: A word with enable and start-of-cell, while no cell is open, opens a cell. Each later word with enable adds 1 byte in narrow mode or 2 bytes in wide mode. The cell closes on the word that reaches the cell length. A word with enable but without start-of-cell, while no cell is open, is dropped.
- R5: A clock with enable low writes nothing and keeps the cell position unchanged.
- R6: With multicast high, address bit i (i = 0..3) enables queue i, and address bit 4 is ignored.
- R7: With multicast low, address bits 4:2 are compared with the chip identifier, and on a match bits 1:0 select the one queue. On a mismatch the whole cell is consumed and nothing is written.
- R8: In in-band mode, the 5-bit route code is taken from data bits 4:0 of the start-of-cell word, and that word is written to the queues as the first word of the cell.
- R9: The destination set is latched when the cell opens and held until it closes. Address changes in the middle of a cell have no effect.
- R10: In wide mode all 18 data bits are written, and the pointer of each target queue advances by 2. In narrow mode data bits 17:9 are written as zero, and the pointer advances by 1.
- R11: A write strobe, the data and the queue's pre-write pointer (8 bits, including the wrap bit) appear on the outputs one cycle after the accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: 18-bit words (2 bytes), 0: 9-bit words |
| cfg_mcast | input | 1 | 1: route code is a queue bitmask, 0: singlecast |
| cfg_inband | input | 1 | 1: route from data bits 4:0 of the first word, 0: from address lines |
| cfg_chip_id | input | 3 | Identifier compared with route code bits 4:2 in singlecast |
| cfg_cell_bytes | input | 8 | Cell length in bytes, 16 to 128 (even in wide mode) |
| in_en | input | 1 | Word valid / transfer enable |
| in_soc | input | 1 | Start of cell, high with the first word |
| in_data | input | 18 | Input data word |
| in_addr | input | 5 | Out-band route code |
| in_clav | output | 1 | Cell space available for the current probe set |
| q_rd_ptr | input | 32 | Per-queue consumer read pointers, 8 bits each, queue 0 in the low bits |
| q_wr_en | output | 4 | Per-queue write strobes |
| q_wr_data | output | 18 | Shared write data |
| q_wr_addr | output | 32 | Per-queue write byte pointers, 8 bits each, queue 0 in the low bits |

## Verification
The overflow property assumes a well-behaved sender. It opens a cell only after cell-available has been high for at least a cycle with the address it is about to use. It never raises start-of-cell inside an open cell. It keeps the cell length even in wide mode. The properties also assume that the mode straps, the chip identifier and the cell length change only while no cell is open and no write is pending. The read pointers are assumed never to pass the write pointers. The stimulus follows these rules. It sets the address two cycles before each cell and checks cell-available there. It changes configuration only after idle cycles. It moves the read pointers only to the write positions it has already predicted, and only while the block is idle.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  typedef enum logic {
    ROUTE_ADDR_LINES = 1'b0,
    ROUTE_DATA_WORD  = 1'b1
  } route_src_e;

  function automatic logic [1:0] bytes_per_word(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/cdr_route_decode.sv
module cdr_route_decode #(
  parameter int NQ     = 4,
  parameter int ADDR_W = 5,
  localparam int SEL_W = $clog2(NQ),
  localparam int ID_W  = ADDR_W - SEL_W
) (
  input  logic              mcast,
  input  logic [ID_W-1:0]   chip_id,
  input  logic [ADDR_W-1:0] code,
  output logic [NQ-1:0]     mask
);

  always_comb begin
    mask = '0;
    if (mcast) begin
      mask = code[NQ-1:0];
    end else if (code[ADDR_W-1:SEL_W] == chip_id) begin
      mask[code[SEL_W-1:0]] = 1'b1;
    end
  end

endmodule

// File: rtl/cdr_queue_ptr.sv
module cdr_queue_ptr #(
  parameter int DEPTH = 128,
  parameter int PTR_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reserve,
  input  logic             write,
  input  logic [1:0]       step,
  input  logic [LEN_W-1:0] cell_bytes,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             room_ok
);

  logic [PTR_W-1:0] res_ptr;
  logic [PTR_W-1:0] fill;
  logic [PTR_W:0]   free_bytes;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      res_ptr <= '0;
    end else begin
      if (reserve) res_ptr <= res_ptr + PTR_W'(cell_bytes);
      if (write)   wr_ptr  <= wr_ptr + PTR_W'(step);
    end
  end

  assign fill       = res_ptr - rd_ptr;
  assign free_bytes = (PTR_W+1)'(DEPTH) - {1'b0, fill};
  assign room_ok    = free_bytes >= (PTR_W+1)'(cell_bytes);

endmodule

// File: rtl/cdr_cell_tracker.sv
module cdr_cell_tracker #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic             in_soc,
  input  logic [1:0]       step,
  input  logic [LEN_W-1:0] cell_bytes,
  output logic             accept,
  output logic             start
);

  logic             open_q;
  logic [LEN_W-1:0] pos_q;
  logic [LEN_W-1:0] pos_base;
  logic [LEN_W-1:0] pos_next;

  assign start    = in_en & in_soc & ~open_q;
  assign accept   = in_en & (in_soc | open_q);
  assign pos_base = start ? '0 : pos_q;
  assign pos_next = pos_base + LEN_W'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      pos_q  <= '0;
    end else if (accept) begin
      if (pos_next >= cell_bytes) begin
        open_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        open_q <= 1'b1;
        pos_q  <= pos_next;
      end
    end
  end

endmodule

// File: rtl/cell_demux_router.sv
module cell_demux_router #(
  parameter int NQ     = 4,
  parameter int DEPTH  = 128,
  parameter int BYTE_W = 9,
  parameter int ADDR_W = 5,
  localparam int DATA_W = 2 * BYTE_W,
  localparam int PTR_W  = $clog2(DEPTH) + 1,
  localparam int LEN_W  = $clog2(DEPTH) + 1,
  localparam int ID_W   = ADDR_W - $clog2(NQ)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wide,
  input  logic                cfg_mcast,
  input  logic                cfg_inband,
  input  logic [ID_W-1:0]     cfg_chip_id,
  input  logic [LEN_W-1:0]    cfg_cell_bytes,
  input  logic                in_en,
  input  logic                in_soc,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [ADDR_W-1:0]   in_addr,
  output logic                in_clav,
  input  logic [NQ*PTR_W-1:0] q_rd_ptr,
  output logic [NQ-1:0]       q_wr_en,
  output logic [DATA_W-1:0]   q_wr_data,
  output logic [NQ*PTR_W-1:0] q_wr_addr
);
  import cdr_pkg::*;

  route_src_e        src_sel;
  logic [1:0]        step;
  logic [ADDR_W-1:0] route_code;
  logic [NQ-1:0]     start_mask;
  logic [NQ-1:0]     probe_mask;
  logic [NQ-1:0]     clav_target;
  logic [NQ-1:0]     dest_q;
  logic [NQ-1:0]     cur_mask;
  logic [NQ-1:0]     write_mask;
  logic [NQ-1:0]     reserve_mask;
  logic [NQ-1:0]     room;
  logic              accept;
  logic              start;
  logic              all_ok;
  logic [PTR_W-1:0]  wr_ptr_arr [NQ];
  logic [PTR_W-1:0]  addr_q     [NQ];

  assign src_sel    = route_src_e'(cfg_inband);
  assign step       = bytes_per_word(cfg_wide);
  assign route_code = (src_sel == ROUTE_DATA_WORD) ? in_data[ADDR_W-1:0] : in_addr;

  cdr_route_decode #(.NQ(NQ), .ADDR_W(ADDR_W)) u_dec_cell (
    .mcast   (cfg_mcast),
    .chip_id (cfg_chip_id),
    .code    (route_code),
    .mask    (start_mask)
  );

  cdr_route_decode #(.NQ(NQ), .ADDR_W(ADDR_W)) u_dec_probe (
    .mcast   (cfg_mcast),
    .chip_id (cfg_chip_id),
    .code    (in_addr),
    .mask    (probe_mask)
  );

  cdr_cell_tracker #(.LEN_W(LEN_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .in_en      (in_en),
    .in_soc     (in_soc),
    .step       (step),
    .cell_bytes (cfg_cell_bytes),
    .accept     (accept),
    .start      (start)
  );

  always_ff @(posedge clk) begin
    if (rst)        dest_q <= '0;
    else if (start) dest_q <= start_mask;
  end

  assign cur_mask     = start ? start_mask : dest_q;
  assign write_mask   = accept ? cur_mask : '0;
  assign reserve_mask = start ? start_mask : '0;
  assign clav_target  = (src_sel == ROUTE_DATA_WORD) ? {NQ{1'b1}} : probe_mask;
  assign all_ok       = &(room | ~clav_target);

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    cdr_queue_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_ptr (
      .clk        (clk),
      .rst        (rst),
      .reserve    (reserve_mask[q]),
      .write      (write_mask[q]),
      .step       (step),
      .cell_bytes (cfg_cell_bytes),
      .rd_ptr     (q_rd_ptr[q*PTR_W +: PTR_W]),
      .wr_ptr     (wr_ptr_arr[q]),
      .room_ok    (room[q])
    );

    always_ff @(posedge clk) begin
      if (rst)                addr_q[q] <= '0;
      else if (write_mask[q]) addr_q[q] <= wr_ptr_arr[q];
    end

    assign q_wr_addr[q*PTR_W +: PTR_W] = addr_q[q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_clav   <= 1'b0;
      q_wr_en   <= '0;
      q_wr_data <= '0;
    end else begin
      in_clav <= all_ok;
      q_wr_en <= write_mask;
      if (accept) begin
        q_wr_data <= cfg_wide ? in_data : {{BYTE_W{1'b0}}, in_data[BYTE_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/cdr_router_checker.sv
module cdr_router_checker #(
  parameter int NQ     = 4,
  parameter int DEPTH  = 128,
  parameter int BYTE_W = 9,
  localparam int DATA_W = 2 * BYTE_W,
  localparam int PTR_W  = $clog2(DEPTH) + 1
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_wide,
  input logic                cfg_mcast,
  input logic                in_en,
  input logic [NQ-1:0]       q_wr_en,
  input logic [DATA_W-1:0]   q_wr_data,
  input logic [NQ*PTR_W-1:0] q_wr_addr,
  input logic [NQ*PTR_W-1:0] q_rd_ptr
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (q_wr_en == '0))
    else $error("write strobe after reset");

  assert_write_after_enable_R5: assert property (@(posedge clk) disable iff (rst)
    (|q_wr_en) |-> $past(in_en))
    else $error("write without enable");

  assert_single_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_mcast |-> $onehot0(q_wr_en))
    else $error("singlecast wrote several queues");

  assert_narrow_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ((|q_wr_en) && !cfg_wide) |-> (q_wr_data[DATA_W-1:BYTE_W] == '0))
    else $error("narrow write carries upper bits");

  for (genvar q = 0; q < NQ; q++) begin : g_ovf
    logic [PTR_W-1:0] used;
    assign used = q_wr_addr[q*PTR_W +: PTR_W] - q_rd_ptr[q*PTR_W +: PTR_W];
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      q_wr_en[q] |-> (used < PTR_W'(DEPTH)))
      else $error("queue written while full");
  end

endmodule

bind cell_demux_router cdr_router_checker #(
  .NQ(NQ), .DEPTH(DEPTH), .BYTE_W(BYTE_W)
) u_chk (.*);

// File: tb/cell_demux_router_tb.sv
`timescale 1ns/1ps
module cell_demux_router_tb;

  localparam logic [2:0] CHIP = 3'b101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wide = 1'b0, cfg_mcast = 1'b0, cfg_inband = 1'b0;
  logic [2:0]  cfg_chip_id = CHIP;
  logic [7:0]  cfg_cell_bytes = 8'd16;
  logic        in_en = 1'b0, in_soc = 1'b0;
  logic [17:0] in_data = '0;
  logic [4:0]  in_addr = '0;
  logic        in_clav;
  logic [31:0] q_rd_ptr;
  logic [3:0]  q_wr_en;
  logic [17:0] q_wr_data;
  logic [31:0] q_wr_addr;
  logic [7:0]  rdp [4];

  int total = 0, bad = 0, cyc = 0;
  int wcnt [4];
  logic [17:0] first_data [4];

  // reference model state
  int          mwp [4], mres [4], mpos;
  bit          mact;
  logic [3:0]  mdest;
  logic        exp_clav = 1'b0;
  logic [3:0]  exp_en = '0;
  logic [17:0] exp_data = '0;
  logic [31:0] exp_addr = '0;

  assign q_rd_ptr = {rdp[3], rdp[2], rdp[1], rdp[0]};

  always #2.5 clk = ~clk;

  cell_demux_router u_dut (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_mcast(cfg_mcast),
    .cfg_inband(cfg_inband), .cfg_chip_id(cfg_chip_id), .cfg_cell_bytes(cfg_cell_bytes),
    .in_en(in_en), .in_soc(in_soc), .in_data(in_data), .in_addr(in_addr),
    .in_clav(in_clav), .q_rd_ptr(q_rd_ptr), .q_wr_en(q_wr_en),
    .q_wr_data(q_wr_data), .q_wr_addr(q_wr_addr)
  );

  function automatic logic [3:0] mdec(input logic mc, input logic [4:0] c);
    if (mc) return c[3:0];
    if (c[4:2] == CHIP) return 4'b0001 << c[1:0];
    return 4'b0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < 4; q++) begin mwp[q] = 0; mres[q] = 0; end
      mpos = 0; mact = 0; mdest = '0;
      exp_clav = 0; exp_en = '0; exp_data = '0; exp_addr = '0;
    end else begin
      logic [3:0] tgt;
      bit ok;
      int stp;
      tgt = cfg_inband ? 4'hf : mdec(cfg_mcast, in_addr);
      ok = 1;
      for (int q = 0; q < 4; q++)
        if (tgt[q] && (128 - ((mres[q] - int'(rdp[q])) & 255)) < int'(cfg_cell_bytes)) ok = 0;
      exp_clav = ok;
      stp = cfg_wide ? 2 : 1;
      exp_en = '0;
      if (in_en && (in_soc || mact)) begin
        if (in_soc && !mact) begin
          mdest = mdec(cfg_mcast, cfg_inband ? in_data[4:0] : in_addr);
          for (int q = 0; q < 4; q++)
            if (mdest[q]) mres[q] = (mres[q] + int'(cfg_cell_bytes)) % 256;
          mpos = 0;
        end
        exp_en = mdest;
        exp_data = cfg_wide ? in_data : (in_data & 18'h001ff);
        for (int q = 0; q < 4; q++)
          if (mdest[q]) begin
            exp_addr[q*8 +: 8] = 8'(mwp[q]);
            mwp[q] = (mwp[q] + stp) % 256;
          end
        mpos += stp;
        if (mpos >= int'(cfg_cell_bytes)) begin mact = 0; mpos = 0; end
        else mact = 1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      chk(in_clav == 1'b0, "R1 clav in reset", in_clav, 0);
      chk(q_wr_en == 4'b0, "R1 strobes in reset", q_wr_en, 0);
    end else begin
      chk(q_wr_en == exp_en, "R4 R5 R6 R7 R8 R9 write strobes", q_wr_en, exp_en);
      chk(in_clav == exp_clav, "R2 cell available", in_clav, exp_clav);
      chk(q_wr_data == exp_data, "R10 R11 write data", q_wr_data, exp_data);
      chk(q_wr_addr == exp_addr, "R3 R11 write pointers", q_wr_addr, exp_addr);
      for (int q = 0; q < 4; q++)
        if (q_wr_en[q]) begin
          if (wcnt[q] == 0) first_data[q] = q_wr_data;
          wcnt[q]++;
        end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_counts();
    for (int q = 0; q < 4; q++) begin wcnt[q] = 0; first_data[q] = '0; end
  endtask

  task automatic settle_and_drain();
    repeat (3) @(negedge clk);
    for (int q = 0; q < 4; q++) rdp[q] = 8'(mwp[q]);
    repeat (2) @(negedge clk);
    clear_counts();
  endtask

  task automatic arm(input logic [4:0] a, input string tag);
    @(negedge clk); in_addr = a;
    repeat (2) @(negedge clk);
    chk(in_clav == 1'b1, tag, in_clav, 1);
  endtask

  task automatic send_cell(input logic [4:0] a, input logic [17:0] d0,
                           input int nw, input int pause_at, input int chg_at);
    for (int i = 0; i < nw; i++) begin
      if (i == pause_at) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk); in_en = 0; in_soc = 0; in_data = 18'h3ffff;
        end
      end
      @(negedge clk);
      in_en = 1; in_soc = (i == 0); in_data = d0 + 18'(i);
      in_addr = (i >= chg_at) ? ~a : a;
    end
    @(negedge clk); in_en = 0; in_soc = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int q = 0; q < 4; q++) rdp[q] = '0;
    clear_counts();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(q_wr_addr == 32'h0, "R1 pointers after reset", q_wr_addr, 0);

    // R7 singlecast match to queue 2, narrow words
    arm(5'b10110, "R2 clav before cell");
    send_cell(5'b10110, 18'h2a500, 16, -1, 99);
    chk(wcnt[2] == 16 && wcnt[0] + wcnt[1] + wcnt[3] == 0, "R7 queue 2 only", wcnt[2], 16);
    chk(first_data[2] == 18'h00100, "R10 narrow upper bits zero", first_data[2], 18'h00100);
    settle_and_drain();

    // R7 identifier mismatch is consumed and dropped
    arm(5'b01110, "R2 clav for foreign id");
    send_cell(5'b01110, 18'h00011, 16, -1, 99);
    chk(wcnt[0] + wcnt[1] + wcnt[2] + wcnt[3] == 0, "R7 mismatch discarded", wcnt[2], 0);
    arm(5'b10100, "R2 clav queue 0");
    send_cell(5'b10100, 18'h00020, 16, -1, 99);
    chk(wcnt[0] == 16, "R4 cell after discard", wcnt[0], 16);
    settle_and_drain();

    // R4 stray words without start-of-cell
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_en = 1; in_soc = 0; in_data = 18'(i);
    end
    @(negedge clk); in_en = 0;
    repeat (2) @(negedge clk);
    chk(wcnt[0] + wcnt[1] + wcnt[2] + wcnt[3] == 0, "R4 stray words dropped",
        wcnt[0] + wcnt[1] + wcnt[2] + wcnt[3], 0);

    // R5 pause mid-cell
    arm(5'b10111, "R2 clav queue 3");
    send_cell(5'b10111, 18'h00040, 16, 7, 99);
    chk(wcnt[3] == 16, "R5 paused cell complete", wcnt[3], 16);
    settle_and_drain();

    // R9 address change mid-cell
    arm(5'b10101, "R2 clav queue 1");
    send_cell(5'b10101, 18'h00060, 16, -1, 3);
    chk(wcnt[1] == 16 && wcnt[0] + wcnt[2] + wcnt[3] == 0, "R9 destination held", wcnt[1], 16);
    settle_and_drain();

    // R6 R10 wide multicast, bit 4 ignored
    cfg_wide = 1; cfg_mcast = 1; cfg_cell_bytes = 8'd32;
    arm(5'b11011, "R2 clav multicast");
    send_cell(5'b11011, 18'h2b3c0, 16, -1, 99);
    chk(wcnt[0] == 16 && wcnt[1] == 16 && wcnt[3] == 16 && wcnt[2] == 0,
        "R6 multicast mask", wcnt[2], 0);
    chk(first_data[0] == 18'h2b3c0, "R10 wide data kept", first_data[0], 18'h2b3c0);
    settle_and_drain();

    // R8 in-band singlecast and multicast
    cfg_wide = 0; cfg_mcast = 0; cfg_inband = 1; cfg_cell_bytes = 8'd16;
    arm(5'b00000, "R2 clav in-band");
    send_cell(5'b00000, 18'h2a415, 16, -1, 99);
    chk(wcnt[1] == 16 && wcnt[0] + wcnt[2] + wcnt[3] == 0, "R8 in-band queue 1", wcnt[1], 16);
    chk(first_data[1] == 18'h00015, "R8 routing word stored", first_data[1], 18'h00015);
    settle_and_drain();
    cfg_mcast = 1;
    arm(5'b00000, "R2 clav in-band multicast");
    send_cell(5'b00000, 18'h0000c, 16, -1, 99);
    chk(wcnt[2] == 16 && wcnt[3] == 16 && wcnt[0] + wcnt[1] == 0, "R8 in-band multicast",
        wcnt[2], 16);
    settle_and_drain();

    // R2 R3 space limit
    cfg_mcast = 0; cfg_inband = 0; cfg_cell_bytes = 8'd64;
    arm(5'b10100, "R2 clav empty queue 0");
    send_cell(5'b10100, 18'h00100, 64, -1, 99);
    arm(5'b10100, "R2 clav half queue 0");
    send_cell(5'b10100, 18'h00140, 64, -1, 99);
    @(negedge clk); in_addr = 5'b10100;
    repeat (2) @(negedge clk);
    chk(in_clav == 1'b0, "R2 full queue blocks", in_clav, 0);
    in_addr = 5'b10101;
    repeat (2) @(negedge clk);
    chk(in_clav == 1'b1, "R2 other queue free", in_clav, 1);
    cfg_inband = 1;
    repeat (2) @(negedge clk);
    chk(in_clav == 1'b0, "R2 in-band probes all queues", in_clav, 0);
    settle_and_drain();
    chk(in_clav == 1'b1, "R2 space after drain", in_clav, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule